// File: doc/BRIEF.md
# Buffered Serial Port with Transmit Cut-Through

This block sits between a processor-side byte interface and a simple serial transmitter/receiver core and holds traffic in both directions in two circular stores. Each store has a power-of-two number of slots, advances its read and write positions by masking, and always keeps one slot free. A full store can therefore always be told apart from an empty one.

On the receive side, the serial core offers one byte per cycle with a valid strobe. The block stores every offered byte while there is room and drops it silently when the store is full. The processor sees the oldest stored byte on a peek output without removing it, and pops that byte with a read strobe.

On the transmit side, a processor write to an empty queue, made while the transmitter reports it is free, goes straight to the transmitter in the same cycle and is never queued. Any other write is queued, and the write also switches on the transmit-service enable. While that enable is on, queued bytes are handed to the transmitter in order on every cycle in which it is free. The enable switches off on the first free cycle that finds the queue empty. A write made while the queue is full is refused and is reported with a one-cycle error pulse. Each direction also has occupancy, empty and full outputs and a flush input.

Top module: `uring_serial_buf`

## Requirements
- R1: Both stores keep first-in first-out order across any number of wraps of their read and write positions. Depths are powers of two.
- R2: A store of N slots holds at most N-1 bytes. The full output is 1 exactly when the count is N-1, and the empty output is 1 exactly when the count is 0.
- R3: A byte offered on `core_rx_valid` while `rx_full` is 1 is discarded. The receive count and the stored bytes are unchanged by it.
- R4: An accepted received byte and the increment of `rx_count` take effect at the same clock edge. When a byte is stored and popped in the same cycle, the count is unchanged.
- R5: When `core_rx_valid` is high for k consecutive cycles and there is room, all k bytes are stored back to back, one per cycle, with no gap.
- R6: `rx_peek_valid` equals (`rx_count` != 0), and `rx_peek_data` shows the oldest byte without removing it. `cpu_rx_rd` removes that byte. A read while the store is empty has no effect.
- R7: When `cpu_tx_wr` is high, `tx_empty` is 1 and `core_tx_free` is 1, the block drives `core_tx_valid`=1 with `core_tx_data`=`cpu_tx_data` in that same cycle, and `tx_count` stays 0.
- R8: A write that is not passed straight through and finds the queue not full is enqueued. At the same edge `tx_count` increments and `tx_req_en` becomes 1.
- R9: While `tx_req_en` is 1 and the queue is not empty, `core_tx_valid`=1 and `core_tx_data` is the oldest queued byte. A cycle with `core_tx_free`=1 removes that byte.
- R10: A cycle with `core_tx_free`=1, `tx_req_en`=1, an empty queue and no write clears `tx_req_en` at the next edge. `core_tx_valid` is 0 whenever the queue is empty and no write is present.
- R11: A write made while `tx_full` is 1 is not stored, and `cpu_tx_err` is 1 for exactly the next cycle.
- R12: `flush_rx` and `flush_tx` zero the count of their store at the next edge. `flush_tx` also clears `tx_req_en`. A flush has priority over any enqueue or dequeue in the same cycle.
- R13: After synchronous reset both counts are 0, both empty flags are 1, both full flags are 0, and `tx_req_en`, `cpu_tx_err`, `rx_peek_valid` and `core_tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_rx_valid | input | 1 | Serial core presents a received byte this cycle |
| core_rx_data | input | DATA_W | Received byte |
| cpu_rx_rd | input | 1 | Pop the oldest received byte |
| flush_rx | input | 1 | Empty the receive store |
| rx_peek_data | output | DATA_W | Oldest received byte |
| rx_peek_valid | output | 1 | Peek data is meaningful |
| rx_count | output | $clog2(RX_DEPTH) | Bytes held in the receive store |
| rx_empty | output | 1 | Receive store holds no byte |
| rx_full | output | 1 | Receive store holds RX_DEPTH-1 bytes |
| cpu_tx_wr | input | 1 | Processor writes a byte to transmit |
| cpu_tx_data | input | DATA_W | Byte to transmit |
| flush_tx | input | 1 | Empty the transmit queue |
| cpu_tx_err | output | 1 | One-cycle pulse after a refused write |
| tx_count | output | $clog2(TX_DEPTH) | Bytes held in the transmit queue |
| tx_empty | output | 1 | Transmit queue holds no byte |
| tx_full | output | 1 | Transmit queue holds TX_DEPTH-1 bytes |
| tx_req_en | output | 1 | Transmit-service enable |
| core_tx_free | input | 1 | Transmitter can take a byte this cycle |
| core_tx_valid | output | 1 | Byte offered to the transmitter |
| core_tx_data | output | DATA_W | Offered byte |

## Verification
The receive side is driven with a long valid burst into an empty store, with bursts that run past capacity so that bytes are dropped, and with repeated fill-and-drain rounds that push both positions through several wraps. Together these separate a drop from a mistaken overwrite and a masking error from a correct wrap. The transmit side is given a single write to an idle transmitter, which must bypass the queue, and a run of writes against a busy transmitter that overfills the queue. A drain follows, so the order, the refusal pulse and the switch-off of the service enable can each be seen on their own. A long stretch of random writes, reads, free cycles and occasional flushes then mixes bypass, enqueue, dequeue and flush in every combination. This is set against a queue-based model that is compared on every cycle.

// File: rtl/uring_pkg.sv
package uring_pkg;

    // Transmit-service enable state
    typedef enum logic {
        REQ_OFF = 1'b0,
        REQ_ON  = 1'b1
    } req_state_e;

    // Per-cycle transmit decision
    typedef struct packed {
        logic bypass;   // write handed straight to transmitter
        logic push;     // write enqueued
        logic pop;      // oldest queued byte handed to transmitter
        logic reject;   // write refused, queue full
        logic req_off;  // free transmitter found queue empty
    } tx_act_t;

    // Advance a ring position by masking (constant time, no compare)
    function automatic logic [15:0] ring_next(input logic [15:0] pos,
                                              input logic [15:0] mask);
        return (pos + 16'd1) & mask;
    endfunction

endpackage

// File: rtl/uring_store.sv
module uring_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head_data,
    output logic [$clog2(DEPTH)-1:0]   count,
    output logic                       empty,
    output logic                       full
);
    import uring_pkg::*;

    localparam int              IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] MASK = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] CAP  = MASK;   // one slot stays free

    logic [W-1:0]     slots [DEPTH];
    logic [IDX_W-1:0] wr_pos, rd_pos, fill;
    logic             push_ok, pop_ok;

    assign push_ok = push && (fill != CAP);
    assign pop_ok  = pop  && (fill != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_pos <= '0;
            rd_pos <= '0;
            fill   <= '0;
        end else begin
            if (push_ok)
                wr_pos <= IDX_W'(ring_next(16'(wr_pos), 16'(MASK)));
            if (pop_ok)
                rd_pos <= IDX_W'(ring_next(16'(rd_pos), 16'(MASK)));
            unique case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            slots[wr_pos] <= push_data;
    end

    assign head_data = slots[rd_pos];
    assign count     = fill;
    assign empty     = (fill == '0);
    assign full      = (fill == CAP);

endmodule

// File: rtl/uring_tx_ctrl.sv
module uring_tx_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         cpu_wr,
    input  logic [W-1:0] cpu_data,
    input  logic         core_free,
    input  logic         q_empty,
    input  logic         q_full,
    input  logic [W-1:0] q_head,
    output logic         q_push,
    output logic         q_pop,
    output logic         core_valid,
    output logic [W-1:0] core_data,
    output logic         req_en,
    output logic         wr_err
);
    import uring_pkg::*;

    req_state_e req_q, req_d;
    tx_act_t    act;
    logic       err_q;

    always_comb begin
        act.bypass  = cpu_wr && q_empty && core_free;
        act.pop     = (req_q == REQ_ON) && !q_empty && core_free;
        act.push    = cpu_wr && !act.bypass && !q_full;
        act.reject  = cpu_wr && q_full;
        act.req_off = (req_q == REQ_ON) && q_empty && core_free;
    end

    always_comb begin
        req_d = req_q;
        if (flush)
            req_d = REQ_OFF;
        else if (act.push)
            req_d = REQ_ON;
        else if (act.req_off)
            req_d = REQ_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= REQ_OFF;
            err_q <= 1'b0;
        end else begin
            req_q <= req_d;
            err_q <= act.reject;
        end
    end

    // Offer depends only on queue state and the write, never on core_free
    assign core_valid = (cpu_wr && q_empty) || ((req_q == REQ_ON) && !q_empty);
    assign core_data  = q_empty ? cpu_data : q_head;
    assign q_push     = act.push;
    assign q_pop      = act.pop;
    assign req_en     = (req_q == REQ_ON);
    assign wr_err     = err_q;

endmodule

// File: rtl/uring_serial_buf.sv
module uring_serial_buf #(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 8,
    parameter int DATA_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        core_rx_valid,
    input  logic [DATA_W-1:0]           core_rx_data,
    input  logic                        cpu_rx_rd,
    input  logic                        flush_rx,
    output logic [DATA_W-1:0]           rx_peek_data,
    output logic                        rx_peek_valid,
    output logic [$clog2(RX_DEPTH)-1:0] rx_count,
    output logic                        rx_empty,
    output logic                        rx_full,
    input  logic                        cpu_tx_wr,
    input  logic [DATA_W-1:0]           cpu_tx_data,
    input  logic                        flush_tx,
    output logic                        cpu_tx_err,
    output logic [$clog2(TX_DEPTH)-1:0] tx_count,
    output logic                        tx_empty,
    output logic                        tx_full,
    output logic                        tx_req_en,
    input  logic                        core_tx_free,
    output logic                        core_tx_valid,
    output logic [DATA_W-1:0]           core_tx_data
);

    // Receive direction: every offered byte is presented to the store,
    // which refuses it when full, so a pending burst drains one per cycle.
    uring_store #(.DEPTH(RX_DEPTH), .W(DATA_W)) u_rx_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_rx),
        .push      (core_rx_valid),
        .push_data (core_rx_data),
        .pop       (cpu_rx_rd),
        .head_data (rx_peek_data),
        .count     (rx_count),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    assign rx_peek_valid = !rx_empty;

    // Transmit direction
    logic              txq_push, txq_pop;
    logic [DATA_W-1:0] txq_head;

    uring_store #(.DEPTH(TX_DEPTH), .W(DATA_W)) u_tx_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_tx),
        .push      (txq_push),
        .push_data (cpu_tx_data),
        .pop       (txq_pop),
        .head_data (txq_head),
        .count     (tx_count),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    uring_tx_ctrl #(.W(DATA_W)) u_tx_ctrl (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_tx),
        .cpu_wr     (cpu_tx_wr),
        .cpu_data   (cpu_tx_data),
        .core_free  (core_tx_free),
        .q_empty    (tx_empty),
        .q_full     (tx_full),
        .q_head     (txq_head),
        .q_push     (txq_push),
        .q_pop      (txq_pop),
        .core_valid (core_tx_valid),
        .core_data  (core_tx_data),
        .req_en     (tx_req_en),
        .wr_err     (cpu_tx_err)
    );

endmodule

// File: rtl/uring_serial_buf_chk.sv
module uring_serial_buf_chk #(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 8,
    parameter int DATA_W   = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        core_rx_valid,
    input logic                        cpu_rx_rd,
    input logic                        flush_rx,
    input logic [DATA_W-1:0]           rx_peek_data,
    input logic                        rx_peek_valid,
    input logic [$clog2(RX_DEPTH)-1:0] rx_count,
    input logic                        rx_full,
    input logic                        cpu_tx_wr,
    input logic [DATA_W-1:0]           cpu_tx_data,
    input logic                        flush_tx,
    input logic                        cpu_tx_err,
    input logic [$clog2(TX_DEPTH)-1:0] tx_count,
    input logic                        tx_empty,
    input logic                        tx_full,
    input logic                        tx_req_en,
    input logic                        core_tx_free,
    input logic                        core_tx_valid,
    input logic [DATA_W-1:0]           core_tx_data
);

    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        rx_full && core_rx_valid && !cpu_rx_rd && !flush_rx |=> $stable(rx_count));

    a_r4_store_counts: assert property (@(posedge clk) disable iff (rst)
        !rx_full && core_rx_valid && !cpu_rx_rd && !flush_rx
        |=> rx_count == $past(rx_count) + 1'b1);

    a_r6_peek_holds: assert property (@(posedge clk) disable iff (rst)
        rx_peek_valid && !cpu_rx_rd && !flush_rx |=> rx_peek_data == $past(rx_peek_data));

    a_r7_bypass_offer: assert property (@(posedge clk) disable iff (rst)
        cpu_tx_wr && tx_empty && core_tx_free
        |-> core_tx_valid && core_tx_data == cpu_tx_data);

    a_r7_bypass_no_queue: assert property (@(posedge clk) disable iff (rst)
        cpu_tx_wr && tx_empty && core_tx_free && !flush_tx |=> tx_empty);

    a_r8_enqueue: assert property (@(posedge clk) disable iff (rst)
        cpu_tx_wr && !tx_empty && !tx_full && !flush_tx && !(core_tx_free && tx_req_en)
        |=> tx_req_en && tx_count == $past(tx_count) + 1'b1);

    a_r10_req_off: assert property (@(posedge clk) disable iff (rst)
        core_tx_free && tx_req_en && tx_empty && !cpu_tx_wr && !flush_tx |=> !tx_req_en);

    a_r10_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
        tx_empty && !cpu_tx_wr |-> !core_tx_valid);

    a_r11_err_after_full: assert property (@(posedge clk) disable iff (rst)
        cpu_tx_wr && tx_full |=> cpu_tx_err);

    a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
        cpu_tx_err |-> $past(cpu_tx_wr && tx_full));

    a_r12_flush_rx: assert property (@(posedge clk) disable iff (rst)
        flush_rx |=> rx_count == '0);

    a_r12_flush_tx: assert property (@(posedge clk) disable iff (rst)
        flush_tx |=> tx_count == '0 && !tx_req_en);

endmodule

bind uring_serial_buf uring_serial_buf_chk #(
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .DATA_W(DATA_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .core_rx_valid (core_rx_valid),
    .cpu_rx_rd     (cpu_rx_rd),
    .flush_rx      (flush_rx),
    .rx_peek_data  (rx_peek_data),
    .rx_peek_valid (rx_peek_valid),
    .rx_count      (rx_count),
    .rx_full       (rx_full),
    .cpu_tx_wr     (cpu_tx_wr),
    .cpu_tx_data   (cpu_tx_data),
    .flush_tx      (flush_tx),
    .cpu_tx_err    (cpu_tx_err),
    .tx_count      (tx_count),
    .tx_empty      (tx_empty),
    .tx_full       (tx_full),
    .tx_req_en     (tx_req_en),
    .core_tx_free  (core_tx_free),
    .core_tx_valid (core_tx_valid),
    .core_tx_data  (core_tx_data)
);

// File: tb/uring_serial_buf_tb.sv
module uring_serial_buf_tb;

    localparam int RXN = 8;
    localparam int TXN = 4;
    localparam int DW  = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic                   rst;
    logic                   core_rx_valid, cpu_rx_rd, flush_rx;
    logic [DW-1:0]          core_rx_data;
    logic [DW-1:0]          rx_peek_data;
    logic                   rx_peek_valid, rx_empty, rx_full;
    logic [$clog2(RXN)-1:0] rx_count;
    logic                   cpu_tx_wr, flush_tx, core_tx_free;
    logic [DW-1:0]          cpu_tx_data;
    logic                   cpu_tx_err, tx_empty, tx_full, tx_req_en, core_tx_valid;
    logic [$clog2(TXN)-1:0] tx_count;
    logic [DW-1:0]          core_tx_data;

    uring_serial_buf #(.RX_DEPTH(RXN), .TX_DEPTH(TXN), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst),
        .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data),
        .cpu_rx_rd(cpu_rx_rd), .flush_rx(flush_rx),
        .rx_peek_data(rx_peek_data), .rx_peek_valid(rx_peek_valid),
        .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full),
        .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data), .flush_tx(flush_tx),
        .cpu_tx_err(cpu_tx_err), .tx_count(tx_count), .tx_empty(tx_empty),
        .tx_full(tx_full), .tx_req_en(tx_req_en), .core_tx_free(core_tx_free),
        .core_tx_valid(core_tx_valid), .core_tx_data(core_tx_data)
    );

    // Behavioural reference
    logic [DW-1:0] m_rx[$];
    logic [DW-1:0] m_tx[$];
    bit            m_req, m_err;

    int    n_cmp = 0, n_bad = 0;
    string phase = "init";

    task automatic chk(string sig, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s [%s]: actual %0d expected %0d", tag, sig, phase, act, exp);
        end
    endtask

    task automatic compare();
        bit exp_tv;
        chk("rx_count", "R4", 32'(rx_count), 32'(m_rx.size()));
        chk("rx_empty", "R2", 32'(rx_empty), 32'(m_rx.size() == 0));
        chk("rx_full", "R2", 32'(rx_full), 32'(m_rx.size() == RXN - 1));
        chk("rx_peek_valid", "R6", 32'(rx_peek_valid), 32'(m_rx.size() != 0));
        if (m_rx.size() != 0)
            chk("rx_peek_data", "R6", 32'(rx_peek_data), 32'(m_rx[0]));
        chk("tx_count", "R8", 32'(tx_count), 32'(m_tx.size()));
        chk("tx_empty", "R2", 32'(tx_empty), 32'(m_tx.size() == 0));
        chk("tx_full", "R2", 32'(tx_full), 32'(m_tx.size() == TXN - 1));
        chk("tx_req_en", "R10", 32'(tx_req_en), 32'(m_req));
        chk("cpu_tx_err", "R11", 32'(cpu_tx_err), 32'(m_err));
        exp_tv = (cpu_tx_wr && m_tx.size() == 0) || (m_req && m_tx.size() != 0);
        chk("core_tx_valid", "R7", 32'(core_tx_valid), 32'(exp_tv));
        if (exp_tv)
            chk("core_tx_data", "R9", 32'(core_tx_data),
                32'((m_tx.size() == 0) ? cpu_tx_data : m_tx[0]));
    endtask

    task automatic advance_model();
        bit t_empty, t_full, r_full, r_nonempty, bypass, pop, push;
        t_empty    = (m_tx.size() == 0);
        t_full     = (m_tx.size() == TXN - 1);
        r_full     = (m_rx.size() == RXN - 1);
        r_nonempty = (m_rx.size() != 0);
        if (rst) begin
            m_rx.delete(); m_tx.delete(); m_req = 0; m_err = 0;
            return;
        end
        m_err = cpu_tx_wr && t_full;
        if (flush_tx) begin
            m_tx.delete(); m_req = 0;
        end else begin
            bypass = cpu_tx_wr && t_empty && core_tx_free;
            pop    = m_req && !t_empty && core_tx_free;
            push   = cpu_tx_wr && !bypass && !t_full;
            if (pop)  void'(m_tx.pop_front());
            if (push) m_tx.push_back(cpu_tx_data);
            if (push) m_req = 1;
            else if (core_tx_free && m_req && t_empty) m_req = 0;
        end
        if (flush_rx) m_rx.delete();
        else begin
            if (cpu_rx_rd && r_nonempty) void'(m_rx.pop_front());
            if (core_rx_valid && !r_full) m_rx.push_back(core_rx_data);
        end
    endtask

    task automatic cyc();
        #1;
        if (!rst) compare();
        advance_model();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst = 1; core_rx_valid = 0; core_rx_data = '0; cpu_rx_rd = 0; flush_rx = 0;
        cpu_tx_wr = 0; cpu_tx_data = '0; flush_tx = 0; core_tx_free = 0;
        m_req = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        phase = "R13 reset state";
        repeat (2) cyc();

        phase = "R5 R4 back-to-back receive";
        for (int i = 0; i < 5; i++) begin
            core_rx_valid = 1; core_rx_data = DW'(8'h10 + i); cyc();
        end
        core_rx_valid = 0; cyc();

        phase = "R6 peek without removal";
        repeat (3) cyc();
        cpu_rx_rd = 1; repeat (2) cyc();
        phase = "R6 read past empty ignored";
        repeat (6) cyc();
        cpu_rx_rd = 0;
        core_rx_valid = 1; core_rx_data = 8'h5c; cyc();
        core_rx_valid = 0; cyc();
        cpu_rx_rd = 1; cyc(); cpu_rx_rd = 0; cyc();

        phase = "R2 R3 R1 overflow and wrap";
        for (int rep = 0; rep < 4; rep++) begin
            for (int i = 0; i < 12; i++) begin
                core_rx_valid = 1; core_rx_data = DW'(rep * 16 + i); cyc();
            end
            core_rx_valid = 0;
            cpu_rx_rd = 1; repeat (3 + rep) cyc(); cpu_rx_rd = 0; cyc();
        end
        cpu_rx_rd = 1; repeat (8) cyc(); cpu_rx_rd = 0;

        phase = "R4 store and pop together";
        core_rx_valid = 1; core_rx_data = 8'h77; cyc();
        for (int i = 0; i < 6; i++) begin
            cpu_rx_rd = 1; core_rx_data = DW'(8'h80 + i); cyc();
        end
        core_rx_valid = 0; cpu_rx_rd = 1; repeat (3) cyc(); cpu_rx_rd = 0;

        phase = "R7 cut-through to idle transmitter";
        core_tx_free = 1; cpu_tx_wr = 1; cpu_tx_data = 8'ha5; cyc();
        cpu_tx_wr = 0; cyc();

        phase = "R8 R11 queue against busy transmitter";
        core_tx_free = 0;
        for (int i = 0; i < 6; i++) begin
            cpu_tx_wr = 1; cpu_tx_data = DW'(8'hc0 + i); cyc();
        end
        cpu_tx_wr = 0; repeat (2) cyc();

        phase = "R9 R10 drain then switch off";
        core_tx_free = 1; repeat (6) cyc();
        core_tx_free = 0; cyc();

        phase = "R12 flush both";
        for (int i = 0; i < 2; i++) begin
            cpu_tx_wr = 1; cpu_tx_data = DW'(8'he0 + i); cyc();
        end
        cpu_tx_wr = 0;
        for (int i = 0; i < 3; i++) begin
            core_rx_valid = 1; core_rx_data = DW'(8'h30 + i); cyc();
        end
        core_rx_valid = 0;
        flush_rx = 1; flush_tx = 1; cyc();
        flush_rx = 0; flush_tx = 0; repeat (2) cyc();

        phase = "R1 R9 random mix";
        for (int i = 0; i < 3000; i++) begin
            core_tx_free  = ($urandom_range(0, 1) == 1);
            cpu_tx_wr     = ($urandom_range(0, 9) < 4);
            cpu_tx_data   = DW'($urandom);
            core_rx_valid = ($urandom_range(0, 1) == 1);
            core_rx_data  = DW'($urandom);
            cpu_rx_rd     = ($urandom_range(0, 9) < 4);
            flush_rx      = ($urandom_range(0, 99) == 0);
            flush_tx      = ($urandom_range(0, 99) == 0);
            cyc();
        end
        core_tx_free = 0; cpu_tx_wr = 0; core_rx_valid = 0; cpu_rx_rd = 0;
        flush_rx = 0; flush_tx = 0;
        cyc();

        finish_run();
    end

endmodule